// File: doc/BRIEF.md
# Side-Effect Register Bank

This block is a bus-side register bank. It sits behind a simple read/write bus with a 32-bit data path and holds a fixed set of fields. Each field sits at its own word address and bit offset. The fields do not all behave alike. Some are plain control registers that can be read back. Some are control values that can only be written. Some report live status and cannot be written. Others have side effects over time: interrupt-style flags cleared by writing ones, event collectors that empty when read, and pulse outputs that fire on a write and carry part of the written word.

One wide control field spans two consecutive word addresses. A parameter chooses its word order, low word first or high word first, and that order applies to reads and to writes alike. The bank also brings out one read strobe and one write strobe for each word address in its window, so neighbouring logic can react to an access without decoding the address again.

A bus access takes place on a rising clock edge where select and enable are both high. Addresses are byte addresses, and each word address step is 4. Write effects appear on the outputs after that edge. Read data is captured at that edge and appears on the read-data port during the following cycle.

Top module: `sfx_regbank`

## Requirements
- R1: A synchronous active-high reset sets every field, the pulse output and the read-data register to zero.
- R2: The control field (width CTRL_W, default 8) lives at byte address 0x00, bits starting at CTRL_OFS (default 4). A write loads it from those bits, and a read returns it at the same bits with zeros in every other bit.
- R3: The command field (width 16) lives at address 0x04, bits starting at 8. A write loads it, and a read of 0x04 returns zero.
- R4: A read of address 0x08 returns the live status input in bits [STAT_W-1:0]. A write to 0x08 has no effect.
- R5: The flag field at address 0x0C, bits [FLAG_W-1:0], picks up each high bit of flag_set on every cycle. A write clears exactly the flag bits whose write-data bits are 1. A flag_set bit in the same cycle as a clearing write wins.
- R6: The event collector at address 0x10, bits starting at 16, ORs acc_evt into itself on every cycle. A read returns its value and clears it. An event that arrives in the same cycle as that read is kept for the next read.
- R7: A write to address 0x14 raises flow_valid for exactly one cycle after the write edge. flow_data then carries write-data bits [FLOW_OFS+FLOW_W-1:FLOW_OFS] (default [11:2]). Reads of 0x14 return zero.
- R8: The wide field (default 48 bits) spans addresses 0x20 and 0x24. With WIDE_BIG=0, 0x20 holds bits [31:0] and 0x24 holds the upper bits, right-aligned.
- R9: With WIDE_BIG=1 the word order is reversed for both reads and writes: 0x20 holds the upper bits, right-aligned, and 0x24 holds bits [31:0].
- R10: Reads of unmapped addresses (0x18, 0x1C, and any address at or past the end of the window) return zero. Writes to them change no field.
- R11: rd_strobe[i] is high during a read access to word i, and wr_strobe[i] during a write access to word i, where i is the byte address divided by 4. At most one strobe bit is ever high.
- R12: Read data appears on bus_rdata in the cycle after the access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Slave select |
| bus_en | input | 1 | Access enable; an access happens when this and bus_sel are both high |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rd_strobe | output | NUM_WORDS | One-hot read strobe per word address |
| wr_strobe | output | NUM_WORDS | One-hot write strobe per word address |
| ctl_value | output | CTRL_W | Read/write control field |
| cmd_value | output | CMD_W | Write-only command field |
| status_in | input | STAT_W | Live status, readable only |
| flag_set | input | FLAG_W | Flag set requests |
| flags | output | FLAG_W | Write-one-to-clear flags |
| acc_evt | input | ACC_W | Event inputs for the collector |
| flow_valid | output | 1 | One-cycle pulse after a write to the flow address |
| flow_data | output | FLOW_W | Payload taken from the write data |
| wide_value | output | WIDE_W | Multi-word control field |

## Verification
Two pairs of actions can land on the same clock edge. In the first, a read of the event collector clears it while a new event arrives. The bench raises acc_evt during the read cycle. It expects that read to return only the events that came earlier, and the next read to return the new event. In the second, a clearing write to the flags lands while flag_set asserts the same bit. The bench expects the bit to stay set. Two instances with opposite word orders share one bus, and every read is compared on both.

// File: rtl/sfx_regbank_pkg.sv
package sfx_regbank_pkg;

  localparam int unsigned BUS_W    = 32;
  localparam int unsigned WORD_INC = 4;

  // word indices (byte address / WORD_INC); neighbours decode the strobes by these
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_CMD  = 1;
  localparam int unsigned IDX_STAT = 2;
  localparam int unsigned IDX_FLAG = 3;
  localparam int unsigned IDX_ACC  = 4;
  localparam int unsigned IDX_FLOW = 5;
  localparam int unsigned IDX_WIDE = 8;

  // number of bus words needed for a field of the given width
  function automatic int unsigned words_for(input int unsigned width);
    return (width + BUS_W - 1) / BUS_W;
  endfunction

  // place right-aligned field bits at a bit offset in a bus word
  function automatic logic [BUS_W-1:0] put_bits(input logic [BUS_W-1:0] val,
                                                 input int unsigned ofs);
    return val << ofs;
  endfunction

  // take field bits from a bus word, right-aligned (caller truncates)
  function automatic logic [BUS_W-1:0] get_bits(input logic [BUS_W-1:0] word,
                                                 input int unsigned ofs);
    return word >> ofs;
  endfunction

  // which chunk of a multi-word field is seen at word step k
  function automatic int unsigned chunk_at(input int unsigned k,
                                           input int unsigned nwords,
                                           input bit big_order);
    return big_order ? (nwords - 1 - k) : k;
  endfunction

  // valid-bit mask of chunk c for a field of the given width
  function automatic logic [BUS_W-1:0] chunk_mask(input int unsigned c,
                                                   input int unsigned width);
    int unsigned lo;
    lo = c * BUS_W;
    if (width >= lo + BUS_W) return '1;
    else if (width <= lo)    return '0;
    else                     return ~('1 << (width - lo));
  endfunction

endpackage

// File: rtl/sfx_decode.sv
module sfx_decode
  import sfx_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 10
) (
  input  logic                 bus_sel,
  input  logic                 bus_en,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_WORDS-1:0] rd_stb,
  output logic [NUM_WORDS-1:0] wr_stb,
  output logic                 rd_access,
  output logic [ADDR_W-3:0]    word_idx
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic access;

  assign access    = bus_sel & bus_en;
  assign rd_access = access & ~bus_write;
  assign word_idx  = bus_addr[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_stb
    logic hit;
    assign hit       = (word_idx == IDX_W'(i));
    assign rd_stb[i] = rd_access & hit;
    assign wr_stb[i] = access & bus_write & hit;
  end

endmodule

// File: rtl/sfx_fields.sv
module sfx_fields
  import sfx_regbank_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 10,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned CTRL_OFS  = 4,
  parameter int unsigned CMD_W     = 16,
  parameter int unsigned CMD_OFS   = 8,
  parameter int unsigned FLAG_W    = 8,
  parameter int unsigned FLAG_OFS  = 0,
  parameter int unsigned ACC_W     = 8,
  parameter int unsigned ACC_OFS   = 16,
  parameter int unsigned FLOW_W    = 10,
  parameter int unsigned FLOW_OFS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WORDS-1:0] rd_stb,
  input  logic [NUM_WORDS-1:0] wr_stb,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [FLAG_W-1:0]    flag_set,
  input  logic [ACC_W-1:0]     acc_evt,
  output logic [CTRL_W-1:0]    ctl_q,
  output logic [CMD_W-1:0]     cmd_q,
  output logic [FLAG_W-1:0]    flags_q,
  output logic [ACC_W-1:0]     acc_q,
  output logic                 flow_valid,
  output logic [FLOW_W-1:0]    flow_data
);
  logic [FLAG_W-1:0] clr_mask;
  logic [FLAG_W-1:0] flags_next;
  logic [ACC_W-1:0]  acc_base;
  logic [ACC_W-1:0]  acc_next;

  // write-one-to-clear: clear first, then new set requests win
  assign clr_mask   = wr_stb[IDX_FLAG] ? FLAG_W'(get_bits(wdata, FLAG_OFS)) : '0;
  assign flags_next = (flags_q & ~clr_mask) | flag_set;

  // clear-on-read collector: events of the read cycle survive the clear
  assign acc_base = rd_stb[IDX_ACC] ? '0 : acc_q;
  assign acc_next = acc_base | acc_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      cmd_q      <= '0;
      flags_q    <= '0;
      acc_q      <= '0;
      flow_valid <= 1'b0;
      flow_data  <= '0;
    end else begin
      if (wr_stb[IDX_CTRL]) ctl_q <= CTRL_W'(get_bits(wdata, CTRL_OFS));
      if (wr_stb[IDX_CMD])  cmd_q <= CMD_W'(get_bits(wdata, CMD_OFS));
      flags_q    <= flags_next;
      acc_q      <= acc_next;
      flow_valid <= wr_stb[IDX_FLOW];
      if (wr_stb[IDX_FLOW]) flow_data <= FLOW_W'(get_bits(wdata, FLOW_OFS));
    end
  end

endmodule

// File: rtl/sfx_wide.sv
module sfx_wide
  import sfx_regbank_pkg::*;
#(
  parameter int unsigned WIDE_W   = 48,
  parameter bit          WIDE_BIG = 1'b0,
  localparam int unsigned NW      = words_for(WIDE_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NW-1:0]       wr_stb,
  input  logic [BUS_W-1:0]    wdata,
  output logic [NW*BUS_W-1:0] rd_words,
  output logic [WIDE_W-1:0]   value
);
  logic [BUS_W-1:0] chunk_q [NW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NW; c++) chunk_q[c] <= '0;
    end else begin
      for (int k = 0; k < NW; k++) begin
        if (wr_stb[k])
          chunk_q[chunk_at(k, NW, WIDE_BIG)] <=
            wdata & chunk_mask(chunk_at(k, NW, WIDE_BIG), WIDE_W);
      end
    end
  end

  logic [NW*BUS_W-1:0] flat;
  for (genvar c = 0; c < NW; c++) begin : g_flat
    assign flat[c*BUS_W +: BUS_W] = chunk_q[c];
  end
  assign value = flat[WIDE_W-1:0];

  // word step k shows the chunk chosen by the word order
  for (genvar k = 0; k < NW; k++) begin : g_rd
    assign rd_words[k*BUS_W +: BUS_W] = chunk_q[chunk_at(k, NW, WIDE_BIG)];
  end

endmodule

// File: rtl/sfx_rdmux.sv
module sfx_rdmux
  import sfx_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 10,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned CTRL_OFS  = 4,
  parameter int unsigned STAT_W    = 12,
  parameter int unsigned FLAG_W    = 8,
  parameter int unsigned FLAG_OFS  = 0,
  parameter int unsigned ACC_W     = 8,
  parameter int unsigned ACC_OFS   = 16,
  parameter int unsigned NW        = 2
) (
  input  logic [ADDR_W-3:0]    word_idx,
  input  logic [CTRL_W-1:0]    ctl_q,
  input  logic [STAT_W-1:0]    status,
  input  logic [FLAG_W-1:0]    flags_q,
  input  logic [ACC_W-1:0]     acc_q,
  input  logic [NW*BUS_W-1:0]  wide_words,
  output logic [BUS_W-1:0]     rd_word,
  output logic                 mapped
);
  int unsigned idx;

  always_comb begin
    idx     = int'(word_idx);
    rd_word = '0;
    mapped  = 1'b1;
    if (idx == IDX_CTRL)       rd_word = put_bits(BUS_W'(ctl_q), CTRL_OFS);
    else if (idx == IDX_CMD)   rd_word = '0;
    else if (idx == IDX_STAT)  rd_word = BUS_W'(status);
    else if (idx == IDX_FLAG)  rd_word = put_bits(BUS_W'(flags_q), FLAG_OFS);
    else if (idx == IDX_ACC)   rd_word = put_bits(BUS_W'(acc_q), ACC_OFS);
    else if (idx == IDX_FLOW)  rd_word = '0;
    else if (idx >= IDX_WIDE && idx < IDX_WIDE + NW)
      rd_word = wide_words[(idx - IDX_WIDE)*BUS_W +: BUS_W];
    else                       mapped = 1'b0;
  end

endmodule

// File: rtl/sfx_regbank.sv
module sfx_regbank
  import sfx_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CTRL_W    = 8,
  parameter int unsigned CTRL_OFS  = 4,
  parameter int unsigned CMD_W     = 16,
  parameter int unsigned CMD_OFS   = 8,
  parameter int unsigned STAT_W    = 12,
  parameter int unsigned FLAG_W    = 8,
  parameter int unsigned ACC_W     = 8,
  parameter int unsigned ACC_OFS   = 16,
  parameter int unsigned FLOW_W    = 10,
  parameter int unsigned FLOW_OFS  = 2,
  parameter int unsigned WIDE_W    = 48,
  parameter bit          WIDE_BIG  = 1'b0,
  localparam int unsigned NW        = words_for(WIDE_W),
  localparam int unsigned NUM_WORDS = IDX_WIDE + NW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_en,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [NUM_WORDS-1:0] rd_strobe,
  output logic [NUM_WORDS-1:0] wr_strobe,
  output logic [CTRL_W-1:0]    ctl_value,
  output logic [CMD_W-1:0]     cmd_value,
  input  logic [STAT_W-1:0]    status_in,
  input  logic [FLAG_W-1:0]    flag_set,
  output logic [FLAG_W-1:0]    flags,
  input  logic [ACC_W-1:0]     acc_evt,
  output logic                 flow_valid,
  output logic [FLOW_W-1:0]    flow_data,
  output logic [WIDE_W-1:0]    wide_value
);
  localparam int unsigned FLAG_OFS = 0;

  // internal events named for the checker
  logic                 rd_access;
  logic                 rd_miss;
  logic                 mapped;
  logic [ADDR_W-3:0]    word_idx;
  logic [ACC_W-1:0]     acc_q;
  logic [BUS_W-1:0]     rd_word;
  logic [NW*BUS_W-1:0]  wide_words;

  sfx_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .bus_sel   (bus_sel),
    .bus_en    (bus_en),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rd_stb    (rd_strobe),
    .wr_stb    (wr_strobe),
    .rd_access (rd_access),
    .word_idx  (word_idx)
  );

  sfx_fields #(
    .NUM_WORDS(NUM_WORDS), .CTRL_W(CTRL_W), .CTRL_OFS(CTRL_OFS),
    .CMD_W(CMD_W), .CMD_OFS(CMD_OFS), .FLAG_W(FLAG_W), .FLAG_OFS(FLAG_OFS),
    .ACC_W(ACC_W), .ACC_OFS(ACC_OFS), .FLOW_W(FLOW_W), .FLOW_OFS(FLOW_OFS)
  ) u_fields (
    .clk        (clk),
    .rst        (rst),
    .rd_stb     (rd_strobe),
    .wr_stb     (wr_strobe),
    .wdata      (bus_wdata),
    .flag_set   (flag_set),
    .acc_evt    (acc_evt),
    .ctl_q      (ctl_value),
    .cmd_q      (cmd_value),
    .flags_q    (flags),
    .acc_q      (acc_q),
    .flow_valid (flow_valid),
    .flow_data  (flow_data)
  );

  sfx_wide #(.WIDE_W(WIDE_W), .WIDE_BIG(WIDE_BIG)) u_wide (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_strobe[IDX_WIDE +: NW]),
    .wdata    (bus_wdata),
    .rd_words (wide_words),
    .value    (wide_value)
  );

  sfx_rdmux #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CTRL_W(CTRL_W), .CTRL_OFS(CTRL_OFS),
    .STAT_W(STAT_W), .FLAG_W(FLAG_W), .FLAG_OFS(FLAG_OFS), .ACC_W(ACC_W),
    .ACC_OFS(ACC_OFS), .NW(NW)
  ) u_rdmux (
    .word_idx   (word_idx),
    .ctl_q      (ctl_value),
    .status     (status_in),
    .flags_q    (flags),
    .acc_q      (acc_q),
    .wide_words (wide_words),
    .rd_word    (rd_word),
    .mapped     (mapped)
  );

  assign rd_miss = rd_access & ~mapped;

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (rd_access) bus_rdata <= mapped ? rd_word : '0;
  end

endmodule

// File: rtl/sfx_regbank_chk.sv
module sfx_regbank_chk
  import sfx_regbank_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 10,
  parameter int unsigned FLAG_W    = 8,
  parameter int unsigned ACC_W     = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_WORDS-1:0] rd_strobe,
  input logic [NUM_WORDS-1:0] wr_strobe,
  input logic [FLAG_W-1:0]    flag_set,
  input logic [FLAG_W-1:0]    flags,
  input logic [ACC_W-1:0]     acc_q,
  input logic [ACC_W-1:0]     acc_evt,
  input logic                 flow_valid,
  input logic                 rd_miss,
  input logic [BUS_W-1:0]     bus_rdata
);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_strobe, wr_strobe})); // R11

  AST_FLOW_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flow_valid == $past(wr_strobe[IDX_FLOW]))); // R7

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_strobe[IDX_ACC])) |-> (acc_q == $past(acc_evt))); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_strobe[IDX_FLAG])) |->
      (flags == ($past(flags) | $past(flag_set)))); // R5

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_miss)) |-> (bus_rdata == '0)); // R10

endmodule

bind sfx_regbank sfx_regbank_chk #(
  .NUM_WORDS(NUM_WORDS), .FLAG_W(FLAG_W), .ACC_W(ACC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_strobe  (rd_strobe),
  .wr_strobe  (wr_strobe),
  .flag_set   (flag_set),
  .flags      (flags),
  .acc_q      (acc_q),
  .acc_evt    (acc_evt),
  .flow_valid (flow_valid),
  .rd_miss    (rd_miss),
  .bus_rdata  (bus_rdata)
);

// File: tb/sfx_regbank_bench.sv
module sfx_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [11:0] status_in = '0;
  logic [7:0]  flag_set = '0;
  logic [7:0]  acc_evt = '0;

  logic [31:0] rdata_l, rdata_b;
  logic [9:0]  rd_strobe, wr_strobe, rd_strobe_b, wr_strobe_b;
  logic [7:0]  ctl_value, ctl_b, flags, flags_b;
  logic [15:0] cmd_value, cmd_b;
  logic        flow_valid, flow_valid_b;
  logic [9:0]  flow_data, flow_data_b;
  logic [47:0] wide_l, wide_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sfx_regbank u_sfx_regbank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .ctl_value(ctl_value),
    .cmd_value(cmd_value), .status_in(status_in), .flag_set(flag_set), .flags(flags),
    .acc_evt(acc_evt), .flow_valid(flow_valid), .flow_data(flow_data),
    .wide_value(wide_l)
  );

  sfx_regbank #(.WIDE_BIG(1'b1)) u_sfx_regbank_big (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .rd_strobe(rd_strobe_b), .wr_strobe(wr_strobe_b), .ctl_value(ctl_b),
    .cmd_value(cmd_b), .status_in(status_in), .flag_set(flag_set), .flags(flags_b),
    .acc_evt(acc_evt), .flow_valid(flow_valid_b), .flow_data(flow_data_b),
    .wide_value(wide_b)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard: expected read data for the little and big instances
  logic [31:0] q_l[$];
  logic [31:0] q_b[$];
  string       q_t[$];
  bit          mon_go = 1'b0;

  always @(posedge clk) begin
    #2;
    if (mon_go) begin
      mon_go = 1'b0;
      if (q_l.size() > 0) begin
        check({q_t[0], " little"}, 64'(rdata_l), 64'(q_l[0]));
        check({q_t[0], " big"},    64'(rdata_b), 64'(q_b[0]));
        void'(q_l.pop_front()); void'(q_b.pop_front()); void'(q_t.pop_front());
      end
    end
  end

  // all bus tasks start and end at a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_en = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_en = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] el,
                        input logic [31:0] eb, input string tag);
    bus_sel = 1; bus_en = 1; bus_write = 0; bus_addr = a;
    q_l.push_back(el); q_b.push_back(eb); q_t.push_back(tag);
    mon_go = 1'b1;
    @(negedge clk);
    bus_sel = 0; bus_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 rdata", 64'(rdata_l), 64'd0);
    check("R1 fields", {ctl_value, cmd_value, flags, flow_valid}, 64'd0);
    check("R1 wide", 64'(wide_l), 64'd0);

    // R2: control field placement
    bus_wr(8'h00, 32'hFFFF_FFFF);
    check("R2 ctl", 64'(ctl_value), 64'hFF);
    bus_rd(8'h00, 32'hFF << 4, 32'hFF << 4, "R2");
    bus_wr(8'h00, 32'h0000_0A50);
    check("R2 ctl pattern", 64'(ctl_value), 64'hA5);

    // R3: write-only field
    bus_wr(8'h04, 32'h00AB_CD00);
    check("R3 cmd", 64'(cmd_value), 64'hABCD);
    bus_rd(8'h04, 32'h0, 32'h0, "R3");

    // R4 and R12: live status, writes ignored, data held after read
    status_in = 12'hA5C;
    bus_rd(8'h08, 32'h0000_0A5C, 32'h0000_0A5C, "R4");
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_rd(8'h08, 32'h0000_0A5C, 32'h0000_0A5C, "R4 after write");
    @(negedge clk);
    check("R12 rdata held", 64'(rdata_l), 64'h0A5C);

    // R11: strobes during an access
    bus_sel = 1; bus_en = 1; bus_write = 0; bus_addr = 8'h08;
    #1 check("R11 read strobe", {rd_strobe, wr_strobe}, {10'b00_0000_0100, 10'b0});
    bus_write = 1; bus_addr = 8'h24;
    #1 check("R11 write strobe", {rd_strobe, wr_strobe}, {10'b0, 10'b10_0000_0000});
    bus_sel = 0; bus_en = 0; bus_write = 0;
    @(negedge clk);

    // R5: write-one-to-clear flags
    flag_set = 8'hF3;
    @(negedge clk);
    flag_set = 8'h00;
    bus_rd(8'h0C, 32'hF3, 32'hF3, "R5 set");
    bus_wr(8'h0C, 32'h0000_0011);
    check("R5 cleared", 64'(flags), 64'hE2);
    flag_set = 8'h20;            // set and clear of bit 5 in one cycle
    bus_wr(8'h0C, 32'h0000_0020);
    flag_set = 8'h00;
    check("R5 set wins", 64'(flags), 64'hE2);

    // R6: collector accumulates and clears on read
    acc_evt = 8'h05; @(negedge clk);
    acc_evt = 8'h20; @(negedge clk);
    acc_evt = 8'h00;
    bus_rd(8'h10, 32'h0025_0000, 32'h0025_0000, "R6 accumulate");
    bus_rd(8'h10, 32'h0, 32'h0, "R6 cleared");
    acc_evt = 8'h01; @(negedge clk);
    acc_evt = 8'h40;             // arrives with the clearing read
    bus_rd(8'h10, 32'h0001_0000, 32'h0001_0000, "R6 same cycle");
    acc_evt = 8'h00;
    bus_rd(8'h10, 32'h0040_0000, 32'h0040_0000, "R6 kept event");

    // R7: write-triggered pulse
    check("R7 idle", 64'(flow_valid), 64'd0);
    bus_wr(8'h14, 32'h0000_0FFC);
    check("R7 pulse", {flow_valid, flow_data}, {1'b1, 10'h3FF});
    @(negedge clk);
    check("R7 one cycle", 64'(flow_valid), 64'd0);
    bus_rd(8'h14, 32'h0, 32'h0, "R7 read zero");

    // R8 and R9: multi-word field in both word orders
    bus_wr(8'h20, 32'h1122_3344);
    bus_wr(8'h24, 32'hAABB_CCDD);
    check("R8 little value", 64'(wide_l), 64'h0000_CCDD_1122_3344);
    check("R9 big value",    64'(wide_b), 64'h0000_3344_AABB_CCDD);
    bus_rd(8'h20, 32'h1122_3344, 32'h0000_3344, "R8 R9 word0");
    bus_rd(8'h24, 32'h0000_CCDD, 32'hAABB_CCDD, "R8 R9 word1");

    // R10: unmapped addresses
    hold = 32'(ctl_value);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h30, 32'hFFFF_FFFF);
    check("R10 no write effect", 64'(ctl_value), 64'(hold));
    check("R10 wide untouched", 64'(wide_l), 64'h0000_CCDD_1122_3344);
    bus_rd(8'h1C, 32'h0, 32'h0, "R10 hole");
    bus_rd(8'hFC, 32'h0, 32'h0, "R10 past window");
    @(negedge clk);

    // R1: reset clears everything again
    rst = 1; @(negedge clk); rst = 0;
    check("R1 reset again", {ctl_value, flags, flow_valid, rdata_l[7:0]}, 64'd0);
    check("R1 wide reset", 64'(wide_b), 64'd0);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule